// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts each 32-bit virtual address from a processor pipeline into one of five address regions, using the current privilege level and the error-level status bit. For each request it gives exactly one outcome. The outcome is either a physical address with read and write permission, a request to consult the translation lookaside buffer, or an address error. An address error is reported as a load fault or a store fault, chosen by the access direction.

The two unmapped kernel windows are translated by dropping the window base. The user region bypasses translation while the error-level bit is set. A strap input selects a fixed-mapping mode for cores built without a TLB. In that mode every access that would have gone to the TLB is instead resolved directly: user addresses are shifted up by a fixed offset, and the upper mapped regions pass through unchanged. Privilege checks stay in force in both modes.

The decode is purely combinational. Its result is captured in one register stage together with a valid strobe, so a response appears one clock after its request.

Top module: `vaddr_segment_decoder`

## Requirements
- R1: An address below 0x80000000 with `err_level` set is resolved directly. The physical address equals the virtual address, in any privilege level and in either mapping mode.
- R2: In normal mode, an address below 0x80000000 with `err_level` clear raises `rsp_tlb_req`. The physical output is 0.
- R3: In kernel level, an address in 0x80000000..0x9FFFFFFF is resolved directly. Its physical address is the address minus 0x80000000.
- R4: In kernel level, an address in 0xA0000000..0xBFFFFFFF is resolved directly. Its physical address is the address minus 0xA0000000.
- R5: `req_priv` is encoded as follows: 0 = user, 1 = supervisor, 2 = kernel, 3 = handled as user. Any non-kernel access to 0x80000000..0xBFFFFFFF is an address error.
- R6: An address in 0xC0000000..0xDFFFFFFF is mapped in supervisor or kernel level and is an address error in user level.
- R7: An address at or above 0xE0000000 is mapped only in kernel level and is an address error in every other level.
- R8: With `fixed_map` set, `rsp_tlb_req` is never raised. Instead:
  - a user-region address with `err_level` clear resolves directly to the address plus 0x40000000;
  - a permitted address at or above 0xC0000000 resolves directly to itself.
- R9: Exactly one of `rsp_direct`, `rsp_tlb_req`, `rsp_adel`, `rsp_ades` is set per valid response. An address error sets `rsp_ades` when `req_write` is 1 and `rsp_adel` when it is 0.
- R10: A direct result grants both `rsp_perm_rd` and `rsp_perm_wr`. Any other result grants neither and drives `rsp_phys` to 0.
- R11: A response appears exactly one clock after its request, with `rsp_valid` following `req_valid`. While `rsp_valid` is low, every flag and `rsp_phys` are 0.
- R12: During and right after synchronous reset, `rsp_valid`, every flag and `rsp_phys` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Virtual address |
| req_priv | input | 2 | Privilege level: 0 user, 1 supervisor, 2 kernel, 3 as user |
| req_write | input | 1 | 1 for a store, 0 for a load or fetch |
| err_level | input | 1 | Error-level status bit |
| fixed_map | input | 1 | Strap: fixed-mapping mode instead of TLB |
| rsp_valid | output | 1 | Response present |
| rsp_phys | output | 32 | Physical address for a direct result, else 0 |
| rsp_direct | output | 1 | Address resolved without TLB |
| rsp_tlb_req | output | 1 | TLB lookup needed |
| rsp_adel | output | 1 | Address error on a load |
| rsp_ades | output | 1 | Address error on a store |
| rsp_perm_rd | output | 1 | Read permitted |
| rsp_perm_wr | output | 1 | Write permitted |

## Verification
The bench drives both edges of every region: 0x7FFFFFFF against 0x80000000, 0x9FFFFFFF against 0xA0000000, 0xBFFFFFFF against 0xC0000000, 0xDFFFFFFF against 0xE0000000, and the last address. An off-by-one region boundary would then show up as the wrong outcome or a wrong physical offset. Each region is tried in every privilege level, including the reserved encoding 3. A decoder that lets a supervisor into the kernel windows, or that treats level 3 as kernel, would return a direct or mapped result where a fault is expected.

Fixed mode is crossed with `err_level` in the user region. A design that applies the 0x40000000 offset with the bit set, or that still raises a TLB request, shows the wrong address or flag. Loads and stores are interleaved so that a swapped fault flag is caught.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef enum logic [1:0] {
    PRIV_USER   = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_KERNEL = 2'd2,
    PRIV_RSVD   = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    SEG_USER  = 3'd0,
    SEG_WIN_A = 3'd1,
    SEG_WIN_B = 3'd2,
    SEG_SMAP  = 3'd3,
    SEG_KMAP  = 3'd4
  } seg_e;

  typedef enum logic [1:0] {
    ACT_DIRECT = 2'd0,
    ACT_MAPPED = 2'd1,
    ACT_FAULT  = 2'd2
  } act_e;

  typedef struct packed {
    logic direct;
    logic tlb_req;
    logic adel;
    logic ades;
    logic perm_rd;
    logic perm_wr;
  } outcome_t;

endpackage

// File: rtl/vsd_region_classify.sv
module vsd_region_classify
  import vsd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output seg_e              seg
);
  localparam int TOP_BITS = 3;

  logic [TOP_BITS-1:0] top;
  assign top = addr[ADDR_W-1 -: TOP_BITS];

  always_comb begin
    unique casez (top)
      3'b0??:  seg = SEG_USER;
      3'b100:  seg = SEG_WIN_A;
      3'b101:  seg = SEG_WIN_B;
      3'b110:  seg = SEG_SMAP;
      default: seg = SEG_KMAP;
    endcase
  end
endmodule

// File: rtl/vsd_access_check.sv
module vsd_access_check
  import vsd_pkg::*;
(
  input  seg_e        seg,
  input  logic [1:0]  priv,
  input  logic        err_level,
  output act_e        act
);
  logic is_kernel;
  logic is_super;

  assign is_kernel = (priv == PRIV_KERNEL);
  assign is_super  = (priv == PRIV_SUPER);

  always_comb begin
    act = ACT_FAULT;
    unique case (seg)
      SEG_USER:  act = err_level ? ACT_DIRECT : ACT_MAPPED;
      SEG_WIN_A,
      SEG_WIN_B: act = is_kernel ? ACT_DIRECT : ACT_FAULT;
      SEG_SMAP:  act = (is_kernel || is_super) ? ACT_MAPPED : ACT_FAULT;
      SEG_KMAP:  act = is_kernel ? ACT_MAPPED : ACT_FAULT;
      default:   act = ACT_FAULT;
    endcase
  end
endmodule

// File: rtl/vsd_phys_translate.sv
module vsd_phys_translate
  import vsd_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter logic [31:0] FIXED_OFFSET = 32'h4000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  seg_e              seg,
  input  act_e              act,
  input  logic              fixed_map,
  input  logic              is_write,
  output logic [ADDR_W-1:0] phys,
  output outcome_t          res
);
  localparam int WIN_BITS = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] WIN_MASK = {{3{1'b0}}, {WIN_BITS{1'b1}}};
  localparam logic [ADDR_W-1:0] OFFS = FIXED_OFFSET[ADDR_W-1:0];

  logic [ADDR_W-1:0] direct_addr;
  logic [ADDR_W-1:0] fixed_addr;
  logic              resolved;

  // Unmapped kernel windows drop their base; user bypass is identity.
  always_comb begin
    if (seg == SEG_WIN_A || seg == SEG_WIN_B) direct_addr = addr & WIN_MASK;
    else                                      direct_addr = addr;
  end

  // Fixed mapping replaces the TLB: user region shifted, upper regions pass.
  always_comb begin
    if (seg == SEG_USER) fixed_addr = addr + OFFS;
    else                 fixed_addr = addr;
  end

  assign resolved = (act == ACT_DIRECT) || (act == ACT_MAPPED && fixed_map);

  always_comb begin
    res         = '0;
    phys        = '0;
    res.tlb_req = (act == ACT_MAPPED) && !fixed_map;
    res.adel    = (act == ACT_FAULT) && !is_write;
    res.ades    = (act == ACT_FAULT) && is_write;
    if (resolved) begin
      res.direct  = 1'b1;
      res.perm_rd = 1'b1;
      res.perm_wr = 1'b1;
      phys        = (act == ACT_DIRECT) ? direct_addr : fixed_addr;
    end
  end
endmodule

// File: rtl/vaddr_segment_decoder.sv
module vaddr_segment_decoder
  import vsd_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter logic [31:0] FIXED_OFFSET = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_priv,
  input  logic              req_write,
  input  logic              err_level,
  input  logic              fixed_map,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic              rsp_direct,
  output logic              rsp_tlb_req,
  output logic              rsp_adel,
  output logic              rsp_ades,
  output logic              rsp_perm_rd,
  output logic              rsp_perm_wr
);
  seg_e              seg;
  act_e              act;
  logic [ADDR_W-1:0] phys_c;
  outcome_t          res_c;
  outcome_t          res_q;

  vsd_region_classify #(.ADDR_W(ADDR_W)) u_cls (
    .addr (req_addr),
    .seg  (seg)
  );

  vsd_access_check u_chk (
    .seg       (seg),
    .priv      (req_priv),
    .err_level (err_level),
    .act       (act)
  );

  vsd_phys_translate #(.ADDR_W(ADDR_W), .FIXED_OFFSET(FIXED_OFFSET)) u_xlt (
    .addr      (req_addr),
    .seg       (seg),
    .act       (act),
    .fixed_map (fixed_map),
    .is_write  (req_write),
    .phys      (phys_c),
    .res       (res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_phys  <= '0;
      res_q     <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_phys  <= req_valid ? phys_c : '0;
      res_q     <= req_valid ? res_c : '0;
    end
  end

  assign rsp_direct  = res_q.direct;
  assign rsp_tlb_req = res_q.tlb_req;
  assign rsp_adel    = res_q.adel;
  assign rsp_ades    = res_q.ades;
  assign rsp_perm_rd = res_q.perm_rd;
  assign rsp_perm_wr = res_q.perm_wr;

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_direct, rsp_tlb_req, rsp_adel, rsp_ades}) == 1);

  // R9
  store_fault_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ades |-> $past(req_write));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_direct && !rsp_tlb_req && !rsp_adel && !rsp_ades && rsp_phys == '0));

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  // R8
  fixed_no_tlb_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(fixed_map)) |-> !rsp_tlb_req);

  // R10
  perm_match_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_direct) |-> (rsp_phys == '0 && !rsp_perm_rd && !rsp_perm_wr));

  // R5
  kwin_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_priv) != PRIV_KERNEL &&
     $past(req_addr[ADDR_W-1 -: 2]) == 2'b10) |-> (rsp_adel || rsp_ades));
endmodule

// File: tb/sim_vaddr_segment_decoder.sv
`timescale 1ns/1ps
module sim_vaddr_segment_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_priv = '0;
  logic        req_write = 1'b0;
  logic        err_level = 1'b0;
  logic        fixed_map = 1'b0;
  logic        rsp_valid, rsp_direct, rsp_tlb_req, rsp_adel, rsp_ades;
  logic        rsp_perm_rd, rsp_perm_wr;
  logic [31:0] rsp_phys;

  int n_tests = 0;
  int n_fail  = 0;

  // {valid, direct, tlb, adel, ades, rd, wr, phys}
  logic [38:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  vaddr_segment_decoder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_priv(req_priv), .req_write(req_write), .err_level(err_level),
    .fixed_map(fixed_map), .rsp_valid(rsp_valid), .rsp_phys(rsp_phys),
    .rsp_direct(rsp_direct), .rsp_tlb_req(rsp_tlb_req), .rsp_adel(rsp_adel),
    .rsp_ades(rsp_ades), .rsp_perm_rd(rsp_perm_rd), .rsp_perm_wr(rsp_perm_wr)
  );

  function automatic logic [38:0] model(input logic v, input logic [31:0] a,
                                        input int pr, input logic er,
                                        input logic w, input logic fx,
                                        output string tag);
    logic kern, sup, dir, tlb, err;
    logic [31:0] p;
    kern = (pr == 2); sup = (pr == 1);
    dir = 0; tlb = 0; err = 0; p = 0;
    if (!v) begin tag = "R11"; return '0; end
    if (a < 32'h8000_0000) begin
      if (er) begin dir = 1; p = a; tag = "R1"; end
      else if (fx) begin dir = 1; p = a + 32'h4000_0000; tag = "R8"; end
      else begin tlb = 1; tag = "R2"; end
    end else if (a < 32'hC000_0000) begin
      if (!kern) begin err = 1; tag = "R5"; end
      else if (a < 32'hA000_0000) begin dir = 1; p = a - 32'h8000_0000; tag = "R3"; end
      else begin dir = 1; p = a - 32'hA000_0000; tag = "R4"; end
    end else begin
      if (a < 32'hE000_0000) tag = "R6"; else tag = "R7";
      if (kern || (sup && a < 32'hE000_0000)) begin
        if (fx) begin dir = 1; p = a; tag = "R8"; end
        else tlb = 1;
      end else err = 1;
    end
    return {1'b1, dir, tlb, err && !w, err && w, dir, dir, p};
  endfunction

  function automatic logic [38:0] observed();
    return {rsp_valid, rsp_direct, rsp_tlb_req, rsp_adel, rsp_ades,
            rsp_perm_rd, rsp_perm_wr, rsp_phys};
  endfunction

  task automatic compare_one(input logic [38:0] e, input string tag);
    logic [38:0] got;
    got = observed();
    n_tests++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s (R9/R10 fields) actual=%h expected=%h", tag, got, e);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input int pr,
                      input logic er, input logic w, input logic fx);
    string t;
    logic [38:0] e;
    @(negedge clk);
    if (exp_q.size() > 0) compare_one(exp_q.pop_front(), tag_q.pop_front());
    req_valid = v; req_addr = a; req_priv = pr[1:0];
    err_level = er; req_write = w; fixed_map = fx;
    e = model(v, a, pr, er, w, fx, t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12: reset holds everything low
    compare_one('0, "R12");
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    compare_one('0, "R12");

    // R1, R2 user region boundary, both error-level states
    step(1, 32'h7FFF_FFFF, 0, 1, 0, 0);
    step(1, 32'h0000_0000, 1, 1, 1, 1);
    step(1, 32'h7FFF_FFFF, 0, 0, 0, 0);
    step(1, 32'h1234_5678, 2, 0, 1, 0);
    // R3, R4 kernel windows edges
    step(1, 32'h8000_0000, 2, 0, 0, 0);
    step(1, 32'h9FFF_FFFF, 2, 0, 1, 0);
    step(1, 32'hA000_0000, 2, 1, 0, 0);
    step(1, 32'hBFFF_FFFF, 2, 0, 1, 1);
    // R5 non-kernel into windows, incl. level 3
    step(1, 32'h8000_0000, 0, 0, 0, 0);
    step(1, 32'hA000_0000, 1, 0, 1, 0);
    step(1, 32'hBFFF_FFFF, 3, 0, 0, 1);
    // R6 supervisor-mapped region
    step(1, 32'hC000_0000, 0, 0, 1, 0);
    step(1, 32'hC000_0000, 1, 0, 0, 0);
    step(1, 32'hDFFF_FFFF, 2, 0, 0, 0);
    step(1, 32'hDFFF_FFFF, 3, 0, 0, 0);
    // R7 kernel-mapped region
    step(1, 32'hE000_0000, 1, 0, 1, 0);
    step(1, 32'hE000_0000, 2, 0, 0, 0);
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 32'hFFFF_FFFF, 2, 0, 1, 0);
    // R8 fixed mapping
    step(1, 32'h0000_0000, 0, 0, 0, 1);
    step(1, 32'h7FFF_FFFF, 1, 0, 1, 1);
    step(1, 32'hC123_4567, 1, 0, 0, 1);
    step(1, 32'hFFFF_FFFF, 2, 0, 0, 1);
    step(1, 32'hE000_0000, 1, 0, 1, 1);
    // R11 idle gaps between requests
    step(0, 32'h8000_0000, 2, 0, 0, 0);
    step(1, 32'h8000_0010, 2, 0, 0, 0);
    step(0, 32'hFFFF_FFFF, 2, 0, 1, 1);

    // R9, R10: mixed random traffic
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 8) != 0, $urandom, $urandom % 4, $urandom % 2,
           $urandom % 2, $urandom % 2);
    end
    step(0, 32'h0, 0, 0, 0, 0);
    @(negedge clk);
    compare_one(exp_q.pop_front(), tag_q.pop_front());

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule